// File: doc/BRIEF.md
# TDM Slot Data Serializer

This block turns parallel data words into the serial data stream of a time-division multiplexed link. It sends one word per slot. A separate timing generator supplies two things: a drive strobe, one cycle wide, for every falling edge of the serial clock, and a slot-start flag that marks the strobe of the first bit of each slot. The slot length in bits is a run-time input. The block keeps its own bit position inside the slot and puts one bit on the serial line for each strobe.

The word length is set apart from the slot length and is chosen from six sizes. The word can sit at the start or at the end of the slot, and it can go out most significant bit first or least significant bit first. Slot bits that the word does not cover are filled from one of four padding modes. When the word is longer than the slot, the bits that do not fit are dropped.

Words arrive on a valid/ready handshake into a one-word look-ahead stage. The word for the next slot can therefore be taken while the current slot is still going out, so there is no gap at a slot boundary. When a slot starts with no word waiting, the whole slot goes out as zeros and an underrun pulse is raised.

The configuration inputs are used as they are, cycle by cycle. They must be held steady for the length of a slot.

Top module: `tdm_slot_serializer`

## Requirements
- R1: `size_code` sets the word length d: 0 gives 8, 1 gives 16, 2 gives 18, 3 gives 20, 4 gives 24, and 5, 6 and 7 give 32. Word bits at index d or above are never sent.
- R2: With `right_just`=0 the word takes the first d transmitted bits of the slot. With `right_just`=1 it takes the last d bits, so its final bit is slot bit `slot_len`-1.
- R3: With `lsb_first`=0 the word's bits go out from bit d-1 down to bit 0. With `lsb_first`=1 they go out from bit 0 up to bit d-1.
- R4: Slot bits that the word does not cover carry the fill selected by `pad_mode`: 0 gives zeros, 1 gives ones, 2 repeats word bit d-1, and 3 repeats word bit 0.
- R5: When `slot_len` < d, only `slot_len` word bits are sent. Left-justified, these are the first ones in transmission order. Right-justified, they are the last ones.
- R6: `sdata` changes only in the cycle after a `drv_stb` cycle. The strobe that carries `slot_start` drives slot bit 0, and each later strobe drives the next bit. Strobes after bit `slot_len`-1 and before the next slot start drive 0.
- R7: If no word is buffered when a slot starts, every bit of that slot is 0 whatever the padding mode, and `underrun` is high for exactly the one cycle in which bit 0 appears.
- R8: `word_ready` is high whenever the look-ahead stage is empty. An accepted word is sent in the next slot to start. The stage empties at that slot start, so the word for the following slot can be accepted during the current slot.
- R9: During and after reset, `sdata`=0, `underrun`=0 and `word_ready`=1. Strobes before the first slot start drive 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| drv_stb | input | 1 | One-cycle strobe for each falling serial-clock edge |
| slot_start | input | 1 | Marks the strobe of slot bit 0 |
| slot_len | input | SLOT_LEN_W | Slot length in bits |
| word_valid | input | 1 | Word offered |
| word_data | input | WORD_W | Offered word |
| word_ready | output | 1 | Look-ahead stage can take a word |
| size_code | input | 3 | Word length select |
| right_just | input | 1 | 1: word at the end of the slot |
| lsb_first | input | 1 | 1: least significant bit sent first |
| pad_mode | input | 2 | Fill for uncovered slot bits |
| sdata | output | 1 | Serial data bit |
| underrun | output | 1 | Pulse: slot started without a word |

## Verification
A wrong bit position or a wrong justification offset shifts the whole slot pattern. The error is visible on `sdata` at the very first strobe after a slot start, where bit 0 carries pad instead of data or the reverse. A look-ahead stage that fails to empty holds `word_ready` low. It also makes a later slot underrun or repeat a word, and this shows at that slot's first bit. A wrong pad selection or a wrong word length shows only on the boundary bits of the slot. For that reason every slot is compared as a complete bit vector, using words whose first and last bits differ.

// File: rtl/tdm_ser_pkg.sv
package tdm_ser_pkg;

  typedef enum logic [1:0] {
    PAD_ZERO = 2'd0,
    PAD_ONE  = 2'd1,
    PAD_MSB  = 2'd2,
    PAD_LSB  = 2'd3
  } pad_mode_e;

  typedef struct packed {
    logic [2:0] size_code;
    logic       right_just;
    logic       lsb_first;
    pad_mode_e  pad;
  } ser_cfg_t;

  // Word length in bits for a size code; unused codes fall back to the widest word.
  function automatic logic [5:0] word_len(input logic [2:0] code);
    case (code)
      3'd0:    return 6'd8;
      3'd1:    return 6'd16;
      3'd2:    return 6'd18;
      3'd3:    return 6'd20;
      3'd4:    return 6'd24;
      default: return 6'd32;
    endcase
  endfunction

endpackage

// File: rtl/tdm_word_stage.sv
module tdm_word_stage #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_data,
  output logic              word_ready,
  input  logic              take,
  output logic              buf_valid,
  output logic [WORD_W-1:0] buf_data
);

  logic accept;

  assign word_ready = !buf_valid;
  assign accept     = word_valid && word_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_valid <= 1'b0;
      buf_data  <= '0;
    end else if (accept) begin
      buf_valid <= 1'b1;
      buf_data  <= word_data;
    end else if (take) begin
      buf_valid <= 1'b0;
    end
  end

  AST_ACCEPT_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && word_ready |=> !word_ready); // R8

  AST_TAKE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    take && !word_valid |=> word_ready); // R8

endmodule

// File: rtl/tdm_slot_track.sv
module tdm_slot_track #(
  parameter int WORD_W     = 32,
  parameter int SLOT_LEN_W = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  drv_stb,
  input  logic                  slot_start,
  input  logic                  buf_valid,
  input  logic [WORD_W-1:0]     buf_data,
  output logic                  load_evt,
  output logic                  underrun_evt,
  output logic [SLOT_LEN_W-1:0] sel_pos,
  output logic [WORD_W-1:0]     sel_word,
  output logic                  sel_empty
);

  localparam logic [SLOT_LEN_W-1:0] POS_MAX = '1;

  logic [SLOT_LEN_W-1:0] cur_pos;
  logic [WORD_W-1:0]     cur_word;
  logic                  cur_empty;

  assign load_evt     = drv_stb && slot_start;
  assign underrun_evt = load_evt && !buf_valid;

  always_comb begin
    if (load_evt) begin
      sel_pos   = '0;
      sel_word  = buf_valid ? buf_data : '0;
      sel_empty = !buf_valid;
    end else begin
      sel_pos   = (cur_pos == POS_MAX) ? POS_MAX : cur_pos + 1'b1;
      sel_word  = cur_word;
      sel_empty = cur_empty;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_pos   <= POS_MAX;
      cur_word  <= '0;
      cur_empty <= 1'b1;
    end else if (drv_stb) begin
      cur_pos   <= sel_pos;
      cur_word  <= sel_word;
      cur_empty <= sel_empty;
    end
  end

  AST_POS_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    drv_stb && slot_start |=> cur_pos == '0); // R6

  AST_POS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_stb |=> $stable(cur_pos)); // R6

endmodule

// File: rtl/tdm_bit_select.sv
module tdm_bit_select
  import tdm_ser_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int SLOT_LEN_W = 6
) (
  input  ser_cfg_t              cfg,
  input  logic [SLOT_LEN_W-1:0] slot_len,
  input  logic [SLOT_LEN_W-1:0] pos,
  input  logic [WORD_W-1:0]     word,
  input  logic                  empty,
  output logic                  bit_out
);

  localparam int IDX_W = $clog2(WORD_W);

  // Maps a transmit position back to the word bit it carries, or to the pad.
  function automatic logic pick_bit(input logic [WORD_W-1:0] w,
                                    input ser_cfg_t c,
                                    input logic [SLOT_LEN_W-1:0] p,
                                    input logic [SLOT_LEN_W-1:0] s,
                                    input logic e);
    int d;
    int off;
    int q;
    logic b;
    d   = int'(word_len(c.size_code));
    off = c.right_just ? (int'(s) - d) : 0;
    q   = int'(p) - off;
    if (e || (p >= s)) begin
      b = 1'b0;
    end else if ((q >= 0) && (q < d)) begin
      b = c.lsb_first ? w[IDX_W'(q)] : w[IDX_W'(d - 1 - q)];
    end else begin
      case (c.pad)
        PAD_ZERO: b = 1'b0;
        PAD_ONE:  b = 1'b1;
        PAD_MSB:  b = w[IDX_W'(d - 1)];
        default:  b = w[0];
      endcase
    end
    return b;
  endfunction

  assign bit_out = pick_bit(word, cfg, pos, slot_len, empty);

endmodule

// File: rtl/tdm_slot_serializer.sv
module tdm_slot_serializer
  import tdm_ser_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int SLOT_LEN_W = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  drv_stb,
  input  logic                  slot_start,
  input  logic [SLOT_LEN_W-1:0] slot_len,
  input  logic                  word_valid,
  input  logic [WORD_W-1:0]     word_data,
  output logic                  word_ready,
  input  logic [2:0]            size_code,
  input  logic                  right_just,
  input  logic                  lsb_first,
  input  logic [1:0]            pad_mode,
  output logic                  sdata,
  output logic                  underrun
);

  logic                  buf_valid;
  logic [WORD_W-1:0]     buf_data;
  logic                  load_evt;
  logic                  underrun_evt;
  logic [SLOT_LEN_W-1:0] sel_pos;
  logic [WORD_W-1:0]     sel_word;
  logic                  sel_empty;
  logic                  next_bit;
  ser_cfg_t              cfg;

  assign cfg = '{size_code: size_code, right_just: right_just,
                 lsb_first: lsb_first, pad: pad_mode_e'(pad_mode)};

  tdm_word_stage #(.WORD_W(WORD_W)) u_stage (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_valid (word_valid),
    .word_data  (word_data),
    .word_ready (word_ready),
    .take       (load_evt),
    .buf_valid  (buf_valid),
    .buf_data   (buf_data)
  );

  tdm_slot_track #(.WORD_W(WORD_W), .SLOT_LEN_W(SLOT_LEN_W)) u_track (
    .clk          (clk),
    .rst_n        (rst_n),
    .drv_stb      (drv_stb),
    .slot_start   (slot_start),
    .buf_valid    (buf_valid),
    .buf_data     (buf_data),
    .load_evt     (load_evt),
    .underrun_evt (underrun_evt),
    .sel_pos      (sel_pos),
    .sel_word     (sel_word),
    .sel_empty    (sel_empty)
  );

  tdm_bit_select #(.WORD_W(WORD_W), .SLOT_LEN_W(SLOT_LEN_W)) u_sel (
    .cfg      (cfg),
    .slot_len (slot_len),
    .pos      (sel_pos),
    .word     (sel_word),
    .empty    (sel_empty),
    .bit_out  (next_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdata    <= 1'b0;
      underrun <= 1'b0;
    end else begin
      underrun <= underrun_evt;
      if (drv_stb) sdata <= next_bit;
    end
  end

  AST_SDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_stb |=> $stable(sdata)); // R6

  AST_BEYOND_SLOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    drv_stb && (sel_pos >= slot_len) |=> !sdata); // R6

  AST_UNDERRUN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> !sdata); // R7

  AST_UNDERRUN_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> $past(drv_stb && slot_start)); // R7

endmodule

// File: tb/tb_tdm_slot_serializer.sv
module tb_tdm_slot_serializer;

  localparam int CLK_P = 10;
  localparam int WDOG  = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        drv_stb = 1'b0;
  logic        slot_start = 1'b0;
  logic [5:0]  slot_len = 6'd16;
  logic        word_valid = 1'b0;
  logic [31:0] word_data = '0;
  logic        word_ready;
  logic [2:0]  size_code = 3'd1;
  logic        right_just = 1'b0;
  logic        lsb_first = 1'b0;
  logic [1:0]  pad_mode = 2'd0;
  logic        sdata;
  logic        underrun;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  tdm_slot_serializer dut (
    .clk(clk), .rst_n(rst_n), .drv_stb(drv_stb), .slot_start(slot_start),
    .slot_len(slot_len), .word_valid(word_valid), .word_data(word_data),
    .word_ready(word_ready), .size_code(size_code), .right_just(right_just),
    .lsb_first(lsb_first), .pad_mode(pad_mode), .sdata(sdata), .underrun(underrun)
  );

  task automatic check(input string req, input bit ok, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Forward model: pad every slot bit, then lay the word in send order from its start position.
  function automatic logic [63:0] model(input logic [31:0] w, input bit has,
                                        input logic [2:0] code, input int s,
                                        input bit rj, input bit lsb,
                                        input logic [1:0] pad);
    int d;
    int start;
    logic padv;
    logic [31:0] seq;
    logic [63:0] r;
    r = '0;
    seq = '0;
    d = (code == 3'd0) ? 8 : (code == 3'd1) ? 16 : (code == 3'd2) ? 18 :
        (code == 3'd3) ? 20 : (code == 3'd4) ? 24 : 32;
    if (!has) return r;
    case (pad)
      2'd0: padv = 1'b0;
      2'd1: padv = 1'b1;
      2'd2: padv = w[d-1];
      default: padv = w[0];
    endcase
    for (int i = 0; i < s; i++) r[i] = padv;
    for (int i = 0; i < d; i++) seq[i] = lsb ? w[i] : w[d-1-i];
    start = rj ? (s - d) : 0;
    for (int i = 0; i < d; i++)
      if ((start + i >= 0) && (start + i < s)) r[start+i] = seq[i];
    return r;
  endfunction

  task automatic push_word(input logic [31:0] w);
    @(negedge clk);
    check("R8 ready before push", word_ready === 1'b1, {63'd0, word_ready}, 64'd1);
    word_valid = 1'b1;
    word_data  = w;
    @(negedge clk);
    word_valid = 1'b0;
  endtask

  // One slot: optional push before, optional push of the next word during the slot.
  task automatic run_slot(input string req, input logic [31:0] w, input bit has,
                          input bit pre, input logic [2:0] code, input int s,
                          input bit rj, input bit lsb, input logic [1:0] pad,
                          input int extra, input bit mid, input logic [31:0] mid_w);
    logic [63:0] exp;
    logic [63:0] act;
    bit hold_ok;
    bit ur_ok;
    hold_ok = 1'b1;
    ur_ok   = 1'b1;
    act     = '0;
    if (pre) push_word(w);
    size_code  = code;
    right_just = rj;
    lsb_first  = lsb;
    pad_mode   = pad;
    slot_len   = 6'(s);
    exp = model(w, has, code, s, rj, lsb, pad);
    for (int p = 0; p < s + extra; p++) begin
      @(negedge clk);
      drv_stb    = 1'b1;
      slot_start = (p == 0);
      @(negedge clk);
      drv_stb    = 1'b0;
      slot_start = 1'b0;
      act[p] = sdata;
      if ((p == 0) && (underrun !== !has)) ur_ok = 1'b0;
      if ((p != 0) && (underrun !== 1'b0)) ur_ok = 1'b0;
      @(negedge clk);
      if (sdata !== act[p]) hold_ok = 1'b0;
      if (mid && (p == 1)) begin
        check("R8 ready after slot start", word_ready === 1'b1, {63'd0, word_ready}, 64'd1);
        word_valid = 1'b1;
        word_data  = mid_w;
        @(negedge clk);
        word_valid = 1'b0;
        check("R8 ready low when full", word_ready === 1'b0, {63'd0, word_ready}, 64'd0);
      end
    end
    check(req, act === exp, act, exp);
    check("R6 hold between strobes", hold_ok, {63'd0, hold_ok}, 64'd1);
    check("R7 underrun pulse", ur_ok, {63'd0, ur_ok}, 64'd1);
  endtask

  task automatic t_reset;
    check("R9 reset sdata", sdata === 1'b0, {63'd0, sdata}, 64'd0);
    check("R9 reset underrun", underrun === 1'b0, {63'd0, underrun}, 64'd0);
    check("R9 reset ready", word_ready === 1'b1, {63'd0, word_ready}, 64'd1);
    // strobes before any slot start drive zero
    @(negedge clk); drv_stb = 1'b1; slot_len = 6'd8;
    @(negedge clk); drv_stb = 1'b0;
    check("R9 strobe before first slot", sdata === 1'b0, {63'd0, sdata}, 64'd0);
  endtask

  task automatic t_basic;
    run_slot("R2 R3 msb left 16/16", 32'h0000_A5C3, 1, 1, 3'd1, 16, 0, 0, 2'd0, 0, 0, '0);
    run_slot("R3 lsb first 24 in 32 right sign pad", 32'h0080_1235, 1, 1, 3'd4, 32, 1, 1, 2'd2, 0, 0, '0);
  endtask

  task automatic t_pad;
    run_slot("R4 pad zeros left, R1 upper bits ignored", 32'hFFFF_FF96, 1, 1, 3'd0, 16, 0, 0, 2'd0, 0, 0, '0);
    run_slot("R4 pad ones right", 32'h0000_0096, 1, 1, 3'd0, 16, 1, 0, 2'd1, 0, 0, '0);
    run_slot("R4 pad msb left", 32'h0000_0096, 1, 1, 3'd0, 16, 0, 0, 2'd2, 0, 0, '0);
    run_slot("R4 pad lsb right", 32'h0000_0035, 1, 1, 3'd0, 16, 1, 0, 2'd3, 0, 0, '0);
  endtask

  task automatic t_sizes;
    run_slot("R1 18-bit in 20 left ones", 32'hFFF2_1C5B, 1, 1, 3'd2, 20, 0, 0, 2'd1, 0, 0, '0);
    run_slot("R1 20-bit in 24 right lsb", 32'h000A_3C71, 1, 1, 3'd3, 24, 1, 1, 2'd0, 0, 0, '0);
    run_slot("R1 32-bit code 5", 32'hC35A_0F81, 1, 1, 3'd5, 32, 0, 0, 2'd0, 0, 0, '0);
    run_slot("R1 code 6 acts as 32", 32'h8123_4567, 1, 1, 3'd6, 36, 0, 0, 2'd1, 0, 0, '0);
  endtask

  task automatic t_narrow;
    run_slot("R5 32 in 16 left", 32'h1234_5678, 1, 1, 3'd5, 16, 0, 0, 2'd0, 0, 0, '0);
    run_slot("R5 32 in 16 right", 32'h1234_5678, 1, 1, 3'd5, 16, 1, 0, 2'd0, 0, 0, '0);
    run_slot("R5 32 in 12 right lsb", 32'h9ABC_DEF1, 1, 1, 3'd5, 12, 1, 1, 2'd1, 0, 0, '0);
  endtask

  task automatic t_underrun;
    run_slot("R7 empty slot zeros despite pad ones", 32'hFFFF_FFFF, 0, 0, 3'd0, 8, 0, 0, 2'd1, 0, 0, '0);
  endtask

  task automatic t_beyond;
    run_slot("R6 strobes past slot end drive 0", 32'h0000_00F0, 1, 1, 3'd0, 10, 0, 0, 2'd1, 3, 0, '0);
  endtask

  task automatic t_handshake;
    run_slot("R8 slot while next word arrives", 32'h0000_B00C, 1, 1, 3'd1, 16, 0, 0, 2'd0, 0, 1, 32'h0000_6E19);
    run_slot("R8 look-ahead word in following slot", 32'h0000_6E19, 1, 0, 3'd1, 16, 0, 0, 2'd0, 0, 0, '0);
    run_slot("R8 stage emptied, next slot underruns", '0, 0, 0, 3'd1, 8, 0, 0, 2'd0, 0, 0, '0);
  endtask

  initial begin
    #(CLK_P * WDOG);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_pad();
    t_sizes();
    t_narrow();
    t_underrun();
    t_beyond();
    t_handshake();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule